// File: doc/BRIEF.md
# Port Logic Terminal Router

This block is the routing and terminal layer of a small programmable logic fabric placed between eight on-chip signals and eight port pins. Channel n pairs chip-side terminal n with pin-side terminal n. Each terminal has a direction code. A channel whose two sides are both in pass-through is a plain wire in each direction. A side configured as input offers its value to the fabric, either raw or through a two-flop synchroniser. A side configured as output is driven only by the lookup cell that has the same index.

The router also builds the input multiplexers for the lookup cells and the trigger multiplexers for the data unit. The lookup cells and the data unit are separate blocks. Their outputs come back in on `cell_out` and `du_out`, and the values the router selects for them leave on `cell_in` and `du_trig`. A small counter holds the fabric inactive for a few clock edges after it is enabled. While the fabric is inactive, every channel behaves as pass-through. Configuration arrives as static input ports.

Top module: `port_terminal_router`

## Requirements
- R1: After reset `fab_active` is 0. It becomes 1 once `fab_en` has been sampled high on 2 consecutive rising edges, or on 3 when `clockless` is 1. It returns to 0 at the first edge that samples `fab_en` low.
- R2: While `fab_active` is 0, and for any channel where both direction codes are 0 (pass-through), `pin_out[n]` equals `chip_in[n]` and `chip_out[n]` equals `pin_in[n]`.
- R3: While `fab_active` is 1, on a channel that is not full pass-through, a side whose direction code is 2 (output) drives `cell_out[n]`. A side with code 0, 1 or 3 (consumed) drives 0.
- R4: A terminal with direction code 1 offers its value to the fabric. If its sync bit is 1 and `clockless` is 0, the offered value comes from a two-flop synchroniser. Otherwise the raw terminal value is offered.
- R5: Synchronisers clear to 0 on reset. They shift only on edges where `fab_en` is 1 and hold their value otherwise.
- R6: Each input of each cell has a 4-bit select, held at `cell_sel[4*(3*c+i) +: 4]`. Codes 0–7 pick `cell_out[code]`. Codes 8–11 pick chip terminal B+code−8, and codes 12–15 pick pin terminal B+code−12, where B is 0 for cells 0–3 and 4 for cells 4–7. The result is placed on `cell_in[3*c+i]`.
- R7: A terminal picked by a cell select yields 0 unless its direction code is 1.
- R8: For input 0 of cell 0, code 0 picks `du_out` instead of `cell_out[0]`.
- R9: Each trigger t has a 4-bit select at `trig_sel[4*t +: 4]`. Code 0 gives 0, code 1 gives 1, code 2 gives `du_out`, codes 8–15 give `cell_out[code−8]`, and codes 3–7 give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst | input | 1 | Synchronous active-high reset |
| fab_en | input | 1 | Fabric enable request |
| clockless | input | 1 | Clockless mode: longer enable delay, synchronisers bypassed |
| chip_dir | input | 16 | 2-bit direction code per chip terminal |
| pin_dir | input | 16 | 2-bit direction code per pin terminal |
| chip_sync | input | 8 | Synchronise enable per chip terminal |
| pin_sync | input | 8 | Synchronise enable per pin terminal |
| cell_sel | input | 96 | 4-bit source select per cell input |
| trig_sel | input | 12 | 4-bit source select per data-unit trigger |
| chip_in | input | 8 | Values from on-chip sources |
| pin_in | input | 8 | Values from the pins |
| cell_out | input | 8 | Outputs of the lookup cells |
| du_out | input | 1 | Output of the data unit |
| chip_out | output | 8 | Values toward on-chip consumers |
| pin_out | output | 8 | Values toward the pins |
| cell_in | output | 24 | Selected inputs for the lookup cells |
| du_trig | output | 3 | Selected data-unit triggers |
| fab_active | output | 1 | Fabric is active |

## Verification
The properties assume that every data and configuration input is stable around the rising clock edge. They also assume that `cell_out` and `du_out` come from outside the block, with no combinational return path through it. The stimulus meets both conditions by changing every input just after the falling edge. It supplies cell and data-unit outputs directly instead of through real lookup cells. The reference model is driven by the same sampled values, so pass-through, enable-delay and synchroniser timing are compared against the design on each falling edge.

// File: rtl/ptr_pkg.sv
package ptr_pkg;
  typedef enum logic [1:0] {
    DIR_PASS = 2'd0,
    DIR_IN   = 2'd1,
    DIR_OUT  = 2'd2,
    DIR_USED = 2'd3
  } dir_e;

  localparam logic [1:0] TRG_CODE_ZERO = 2'd0;
  localparam logic [1:0] TRG_CODE_ONE  = 2'd1;
  localparam logic [1:0] TRG_CODE_DU   = 2'd2;
endpackage

// File: rtl/ptr_enable_gate.sv
module ptr_enable_gate #(
  parameter int DLY_CLOCKED   = 2,
  parameter int DLY_CLOCKLESS = 3,
  localparam int MAXD = (DLY_CLOCKED > DLY_CLOCKLESS) ? DLY_CLOCKED : DLY_CLOCKLESS,
  localparam int CW   = $clog2(MAXD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clockless,
  output logic active
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] target;

  assign target = clockless ? CW'(DLY_CLOCKLESS) : CW'(DLY_CLOCKED);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
    end else if (cnt < target) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign active = (cnt >= target);
endmodule

// File: rtl/ptr_sync_bank.sv
module ptr_sync_bank #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= '0;
    end else if (en) begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ptr_src_mux.sv
module ptr_src_mux #(
  parameter int NCH        = 8,
  parameter int BASE       = 0,
  parameter bit DU_AT_ZERO = 1'b0,
  localparam int IW    = $clog2(NCH),
  localparam int SEL_W = IW + 1
) (
  input  logic [SEL_W-1:0] sel,
  input  logic [NCH-1:0]   cell_out,
  input  logic             du_out,
  input  logic [NCH-1:0]   chip_term,
  input  logic [NCH-1:0]   pin_term,
  output logic             y
);
  logic [IW-1:0] off;
  logic [IW-1:0] tidx;

  assign off  = sel[IW-1:0];
  assign tidx = IW'(BASE) + {1'b0, off[IW-2:0]};

  always_comb begin
    if (!sel[SEL_W-1]) begin
      if (DU_AT_ZERO && (off == '0)) y = du_out;
      else                           y = cell_out[off];
    end else if (!off[IW-1]) begin
      y = chip_term[tidx];
    end else begin
      y = pin_term[tidx];
    end
  end
endmodule

// File: rtl/ptr_channel.sv
module ptr_channel
  import ptr_pkg::*;
(
  input  logic       active,
  input  logic [1:0] cdir,
  input  logic [1:0] pdir,
  input  logic       chip_in,
  input  logic       pin_in,
  input  logic       cell_bit,
  output logic       chip_out,
  output logic       pin_out
);
  logic wire_through;

  assign wire_through = !active ||
                        ((dir_e'(cdir) == DIR_PASS) && (dir_e'(pdir) == DIR_PASS));

  always_comb begin
    if (wire_through) begin
      pin_out  = chip_in;
      chip_out = pin_in;
    end else begin
      pin_out  = (dir_e'(pdir) == DIR_OUT) ? cell_bit : 1'b0;
      chip_out = (dir_e'(cdir) == DIR_OUT) ? cell_bit : 1'b0;
    end
  end
endmodule

// File: rtl/port_terminal_router.sv
module port_terminal_router
  import ptr_pkg::*;
#(
  parameter int NCH           = 8,
  parameter int SYNC_STAGES   = 2,
  parameter int DLY_CLOCKED   = 2,
  parameter int DLY_CLOCKLESS = 3,
  localparam int IW    = $clog2(NCH),
  localparam int SEL_W = IW + 1,
  localparam int NIN   = 3,
  localparam int HALF  = NCH / 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     fab_en,
  input  logic                     clockless,
  input  logic [2*NCH-1:0]         chip_dir,
  input  logic [2*NCH-1:0]         pin_dir,
  input  logic [NCH-1:0]           chip_sync,
  input  logic [NCH-1:0]           pin_sync,
  input  logic [NCH*NIN*SEL_W-1:0] cell_sel,
  input  logic [NIN*SEL_W-1:0]     trig_sel,
  input  logic [NCH-1:0]           chip_in,
  input  logic [NCH-1:0]           pin_in,
  input  logic [NCH-1:0]           cell_out,
  input  logic                     du_out,
  output logic [NCH-1:0]           chip_out,
  output logic [NCH-1:0]           pin_out,
  output logic [NCH*NIN-1:0]       cell_in,
  output logic [NIN-1:0]           du_trig,
  output logic                     fab_active
);
  logic [NCH-1:0] chip_s, pin_s;
  logic [NCH-1:0] chip_term, pin_term;

  ptr_enable_gate #(
    .DLY_CLOCKED(DLY_CLOCKED), .DLY_CLOCKLESS(DLY_CLOCKLESS)
  ) u_gate (
    .clk(clk), .rst(rst), .en(fab_en), .clockless(clockless), .active(fab_active)
  );

  ptr_sync_bank #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_chip (
    .clk(clk), .rst(rst), .en(fab_en), .d(chip_in), .q(chip_s)
  );

  ptr_sync_bank #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync_pin (
    .clk(clk), .rst(rst), .en(fab_en), .d(pin_in), .q(pin_s)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    logic use_sync_c, use_sync_p;
    assign use_sync_c = chip_sync[n] && !clockless;
    assign use_sync_p = pin_sync[n]  && !clockless;
    assign chip_term[n] = (dir_e'(chip_dir[2*n +: 2]) == DIR_IN) &&
                          (use_sync_c ? chip_s[n] : chip_in[n]);
    assign pin_term[n]  = (dir_e'(pin_dir[2*n +: 2]) == DIR_IN) &&
                          (use_sync_p ? pin_s[n] : pin_in[n]);

    ptr_channel u_chan (
      .active(fab_active),
      .cdir(chip_dir[2*n +: 2]), .pdir(pin_dir[2*n +: 2]),
      .chip_in(chip_in[n]), .pin_in(pin_in[n]), .cell_bit(cell_out[n]),
      .chip_out(chip_out[n]), .pin_out(pin_out[n])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_cell
    for (genvar i = 0; i < NIN; i++) begin : g_in
      ptr_src_mux #(
        .NCH(NCH),
        .BASE((c < HALF) ? 0 : HALF),
        .DU_AT_ZERO((c == 0) && (i == 0))
      ) u_mux (
        .sel(cell_sel[SEL_W*(NIN*c+i) +: SEL_W]),
        .cell_out(cell_out), .du_out(du_out),
        .chip_term(chip_term), .pin_term(pin_term),
        .y(cell_in[NIN*c+i])
      );
    end
  end

  for (genvar t = 0; t < NIN; t++) begin : g_trig
    logic [SEL_W-1:0] ts;
    assign ts = trig_sel[SEL_W*t +: SEL_W];
    always_comb begin
      if (ts[SEL_W-1])                              du_trig[t] = cell_out[ts[IW-1:0]];
      else if (ts == SEL_W'(TRG_CODE_ONE))          du_trig[t] = 1'b1;
      else if (ts == SEL_W'(TRG_CODE_DU))           du_trig[t] = du_out;
      else                                          du_trig[t] = 1'b0;
    end
  end
endmodule

// File: rtl/ptr_router_checker.sv
module ptr_router_checker #(
  parameter int NCH = 8,
  parameter int SW  = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fab_en,
  input logic             fab_active,
  input logic [2*NCH-1:0] chip_dir,
  input logic [2*NCH-1:0] pin_dir,
  input logic [NCH-1:0]   chip_in,
  input logic [NCH-1:0]   pin_in,
  input logic [NCH-1:0]   chip_out,
  input logic [NCH-1:0]   pin_out,
  input logic [NCH-1:0]   cell_out,
  input logic             du_out,
  input logic [SW-1:0]    sel0,
  input logic             cell_in0,
  input logic [SW-1:0]    tsel0,
  input logic             trig0
);
  assert_enable_history_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(fab_active) |-> ($past(fab_en) && $past(fab_en, 2)));

  assert_drop_on_disable_R1: assert property (@(posedge clk) disable iff (rst)
    !fab_en |=> !fab_active);

  assert_idle_wires_R2: assert property (@(posedge clk) disable iff (rst)
    !fab_active |-> ((pin_out == chip_in) && (chip_out == pin_in)));

  for (genvar n = 0; n < NCH; n++) begin : g_out
    assert_pin_driver_R3: assert property (@(posedge clk) disable iff (rst)
      (fab_active && (chip_dir[2*n +: 2] != 2'd0) && (pin_dir[2*n +: 2] == 2'd2))
        |-> (pin_out[n] == cell_out[n]));
    assert_chip_driver_R3: assert property (@(posedge clk) disable iff (rst)
      (fab_active && (pin_dir[2*n +: 2] != 2'd0) && (chip_dir[2*n +: 2] == 2'd2))
        |-> (chip_out[n] == cell_out[n]));
  end

  assert_du_source_R8: assert property (@(posedge clk) disable iff (rst)
    (sel0 == '0) |-> (cell_in0 == du_out));

  assert_trig_one_R9: assert property (@(posedge clk) disable iff (rst)
    (tsel0 == SW'(1)) |-> trig0);
endmodule

bind port_terminal_router ptr_router_checker #(.NCH(NCH), .SW(SEL_W)) u_checker (
  .clk(clk), .rst(rst), .fab_en(fab_en), .fab_active(fab_active),
  .chip_dir(chip_dir), .pin_dir(pin_dir),
  .chip_in(chip_in), .pin_in(pin_in), .chip_out(chip_out), .pin_out(pin_out),
  .cell_out(cell_out), .du_out(du_out),
  .sel0(cell_sel[SEL_W-1:0]), .cell_in0(cell_in[0]),
  .tsel0(trig_sel[SEL_W-1:0]), .trig0(du_trig[0])
);

// File: tb/port_terminal_router_test.sv
module port_terminal_router_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fab_en = 1'b0;
  logic        clockless = 1'b0;
  logic [15:0] chip_dir = '0, pin_dir = '0;
  logic [7:0]  chip_sync = '0, pin_sync = '0;
  logic [95:0] cell_sel = '0;
  logic [11:0] trig_sel = '0;
  logic [7:0]  chip_in = '0, pin_in = '0, cell_out = '0;
  logic        du_out = 1'b0;
  logic [7:0]  chip_out, pin_out;
  logic [23:0] cell_in;
  logic [2:0]  du_trig;
  logic        fab_active;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string phase = "R1";

  // model state
  int   m_cnt = 0;
  logic m_c1 [8], m_c2 [8], m_p1 [8], m_p2 [8];

  always #2 clk = ~clk;

  port_terminal_router uut (
    .clk(clk), .rst(rst), .fab_en(fab_en), .clockless(clockless),
    .chip_dir(chip_dir), .pin_dir(pin_dir), .chip_sync(chip_sync), .pin_sync(pin_sync),
    .cell_sel(cell_sel), .trig_sel(trig_sel),
    .chip_in(chip_in), .pin_in(pin_in), .cell_out(cell_out), .du_out(du_out),
    .chip_out(chip_out), .pin_out(pin_out), .cell_in(cell_in),
    .du_trig(du_trig), .fab_active(fab_active)
  );

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_cnt = 0;
      for (int k = 0; k < 8; k++) begin
        m_c1[k] = 0; m_c2[k] = 0; m_p1[k] = 0; m_p2[k] = 0;
      end
    end else if (!fab_en) begin
      m_cnt = 0;
    end else begin
      if (m_cnt < (clockless ? 3 : 2)) m_cnt++;
      for (int k = 0; k < 8; k++) begin
        m_c2[k] = m_c1[k]; m_c1[k] = chip_in[k];
        m_p2[k] = m_p1[k]; m_p1[k] = pin_in[k];
      end
    end
  end

  function automatic logic m_active();
    return m_cnt >= (clockless ? 3 : 2);
  endfunction

  function automatic logic m_term(bit pin_side, int n);
    int   d    = pin_side ? int'(pin_dir[2*n +: 2]) : int'(chip_dir[2*n +: 2]);
    logic sy   = pin_side ? pin_sync[n] : chip_sync[n];
    logic raw  = pin_side ? pin_in[n] : chip_in[n];
    logic held = pin_side ? m_p2[n] : m_c2[n];
    if (d != 1) return 1'b0;
    return (sy && !clockless) ? held : raw;
  endfunction

  function automatic logic [7:0] m_pin_out();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      int cd = int'(chip_dir[2*n +: 2]);
      int pd = int'(pin_dir[2*n +: 2]);
      if (!m_active() || (cd == 0 && pd == 0)) r[n] = chip_in[n];
      else r[n] = (pd == 2) ? cell_out[n] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [7:0] m_chip_out();
    logic [7:0] r;
    for (int n = 0; n < 8; n++) begin
      int cd = int'(chip_dir[2*n +: 2]);
      int pd = int'(pin_dir[2*n +: 2]);
      if (!m_active() || (cd == 0 && pd == 0)) r[n] = pin_in[n];
      else r[n] = (cd == 2) ? cell_out[n] : 1'b0;
    end
    return r;
  endfunction

  function automatic logic [23:0] m_cell_in();
    logic [23:0] r;
    for (int c = 0; c < 8; c++) begin
      for (int i = 0; i < 3; i++) begin
        int code = int'(cell_sel[4*(3*c+i) +: 4]);
        int base = (c < 4) ? 0 : 4;
        if (c == 0 && i == 0 && code == 0) r[3*c+i] = du_out;
        else if (code < 8)  r[3*c+i] = cell_out[code];
        else if (code < 12) r[3*c+i] = m_term(0, base + code - 8);
        else                r[3*c+i] = m_term(1, base + code - 12);
      end
    end
    return r;
  endfunction

  function automatic logic [2:0] m_trig();
    logic [2:0] r;
    for (int t = 0; t < 3; t++) begin
      int code = int'(trig_sel[4*t +: 4]);
      if (code >= 8)      r[t] = cell_out[code-8];
      else if (code == 1) r[t] = 1'b1;
      else if (code == 2) r[t] = du_out;
      else                r[t] = 1'b0;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) actual=%h expected=%h at cycle %0d", tag, phase, act, exp, cycles);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    check("R1 fab_active", 32'(fab_active), 32'(m_active()));
    check("R2/R3 pin_out", 32'(pin_out), 32'(m_pin_out()));
    check("R2/R3 chip_out", 32'(chip_out), 32'(m_chip_out()));
    check("R6 cell_in", 32'(cell_in), 32'(m_cell_in()));
    check("R9 du_trig", 32'(du_trig), 32'(m_trig()));
  endtask

  task automatic rnd_data();
    chip_in = 8'($urandom); pin_in = 8'($urandom);
    cell_out = 8'($urandom); du_out = 1'($urandom);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      tick();
      rnd_data();
    end
  endtask

  initial begin
    // R1: reset state
    phase = "R1";
    repeat (3) tick();
    check("R1 reset inactive", 32'(fab_active), 32'd0);
    rst = 1'b0;

    // R2: disabled channels are wires whatever the codes
    phase = "R2";
    chip_dir = 16'($urandom); pin_dir = 16'($urandom);
    run(10);

    // R1: enable delay, clocked then clockless
    phase = "R1";
    fab_en = 1'b1;
    tick(); check("R1 one edge", 32'(fab_active), 32'd0);
    tick(); check("R1 two edges", 32'(fab_active), 32'd1);
    fab_en = 1'b0;
    tick(); check("R1 drop", 32'(fab_active), 32'd0);
    clockless = 1'b1; fab_en = 1'b1;
    tick(); tick(); check("R1 clockless two edges", 32'(fab_active), 32'd0);
    tick(); check("R1 clockless three edges", 32'(fab_active), 32'd1);
    clockless = 1'b0;

    // R3: output drivers and consumed sides
    phase = "R3";
    for (int k = 0; k < 20; k++) begin
      chip_dir = 16'($urandom); pin_dir = 16'($urandom);
      tick(); rnd_data();
    end

    // R4: input terminals, synchronised and raw
    phase = "R4";
    chip_dir = 16'h5555; pin_dir = 16'h5555;
    for (int c = 0; c < 8; c++)
      for (int i = 0; i < 3; i++)
        cell_sel[4*(3*c+i) +: 4] = 4'(8 + 4*(i % 2) + ((c + i) % 4));
    for (int k = 0; k < 30; k++) begin
      chip_sync = 8'($urandom); pin_sync = 8'($urandom);
      clockless = (k >= 20);
      tick(); rnd_data();
    end
    clockless = 1'b0;

    // R5: synchronisers hold while disabled, clear on reset
    phase = "R5";
    chip_sync = 8'hFF; pin_sync = 8'hFF;
    run(4);
    fab_en = 1'b0;
    run(8);
    rst = 1'b1; run(2); rst = 1'b0;
    fab_en = 1'b1; run(4);

    // R7: terminals not configured as input read as 0
    phase = "R7";
    for (int k = 0; k < 25; k++) begin
      chip_dir = 16'($urandom); pin_dir = 16'($urandom);
      for (int j = 0; j < 24; j++) cell_sel[4*j +: 4] = 4'(8 + ($urandom % 8));
      tick(); rnd_data();
    end

    // R8: data-unit output on cell 0 input 0
    phase = "R8";
    cell_sel[3:0] = 4'd0;
    for (int k = 0; k < 8; k++) begin
      du_out = k[0]; cell_out = 8'($urandom);
      tick();
    end

    // R9: trigger selects over every code
    phase = "R9";
    for (int k = 0; k < 32; k++) begin
      trig_sel = {4'($urandom), 4'($urandom), 4'(k % 16)};
      tick(); rnd_data();
    end

    // R6: everything random
    phase = "R6";
    for (int k = 0; k < 300; k++) begin
      chip_dir = 16'($urandom); pin_dir = 16'($urandom);
      chip_sync = 8'($urandom); pin_sync = 8'($urandom);
      cell_sel = {$urandom, $urandom, $urandom};
      trig_sel = 12'($urandom);
      if (k % 37 == 0) fab_en = ~fab_en;
      if (k % 53 == 0) clockless = ~clockless;
      tick(); rnd_data();
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule